// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command, address and data-mask pins of a four-bank mobile SDRAM interface. On every rising clock edge it turns the pin levels into one command. The clock-enable level picks between the two meanings of the shared opcodes. From the decoded stream it keeps an open/closed flag and an active row for each bank. It also holds the values last written to the base and extended mode registers.

The block follows the single data burst that a READ or WRITE starts, using a configurable burst length. From that burst and the data mask it produces two signals:

- a write-enable that the mask blocks in the same cycle;
- a read output-enable that the mask turns off two edges later.

Single-cycle error pulses report protocol misuse: a burst to a closed bank, an activate to an open bank, a misplaced burst terminate, and a mode write to a reserved select code. Timing parameters, refresh intervals and data contents are not checked.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Pins are sampled on the rising edge, and `cmd` shows the decoded command from the edge that sampled it. With `cs_n` high, the command is NOP (0). With `cs_n` low, the three-bit code {ras_n,cas_n,we_n} decodes as: 111 NOP (0), 011 ACTIVE (1), 101 READ (2), 100 WRITE (3), 110 BURST STOP (4), 010 PRECHARGE (5), 001 AUTO REFRESH (6), 000 MODE WRITE (7).
- R2: With `cke` low, code 110 decodes as DEEP POWER-DOWN (8) and code 001 decodes as SELF-REFRESH (9). Every other code with `cke` low decodes as NOP and changes no state. Refresh commands ignore the address and bank pins.
- R3: An ACTIVE to a closed bank `ba` sets `bank_open[ba]` and stores `addr[12:0]` in that bank's row field, `open_rows[13*ba +: 13]`.
- R4: An ACTIVE to an open bank pulses `err_reopen` for one cycle and leaves the bank flags and rows unchanged.
- R5: A READ or WRITE to a closed bank pulses `err_closed` and starts no burst.
- R6: A PRECHARGE with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes all banks, whatever `ba` is.
- R7: A READ or WRITE with `addr[10]` high closes its bank at the edge that samples the last beat, BURST_LEN-1 edges after the command. If a new accepted READ or WRITE interrupts such a burst, its bank closes at the interrupting edge. With `addr[10]` low the bank stays open.
- R8: A BURST STOP is legal only while a burst started without auto precharge still has beats left, and it ends that burst. In every other case it pulses `err_bst`.
- R9: A MODE WRITE with `ba`=00 loads `addr` into `mode_reg`, and with `ba`=01 loads it into `ext_mode_reg`. With `ba`=10 or 11 it pulses `err_reserved` and loads neither register.
- R10: `wr_en` is high after an edge that samples a write beat with `dqm` low, and low after a write beat with `dqm` high.
- R11: A read beat sampled with `dqm` low drives `rd_oe` high after the edge two edges later. With `dqm` high at that beat, `rd_oe` stays low.
- R12: While `rst_n` is low, all banks are closed and all rows, mode registers, `cmd`, enables and error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| dqm | input | 1 | Data mask pin |
| ba | input | 2 | Bank select pins |
| addr | input | 13 | Address pins, bit 10 is the auto-precharge / all-banks flag |
| cmd | output | 4 | Decoded command code of the last sampled edge |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Active row per bank, 13 bits each |
| mode_reg | output | 13 | Last base mode value |
| ext_mode_reg | output | 13 | Last extended mode value |
| wr_en | output | 1 | Write beat accepted, not masked |
| rd_oe | output | 1 | Read output enable after mask latency |
| err_closed | output | 1 | Burst to a closed bank |
| err_reopen | output | 1 | Activate to an open bank |
| err_bst | output | 1 | Illegal burst stop |
| err_reserved | output | 1 | Mode write with a reserved select |

## Verification
Directed sequences exercise each opcode with `cke` high and low, and with `cs_n` high. This separates a decoder that ignores clock enable or chip select from a correct one. Auto-precharge writes carry a mask pattern of 0,1,0,0, and plain reads have a mask high in mid-burst. These patterns tell a same-cycle write mask from a delayed one, and a two-edge read mask latency from a one- or three-edge one. They also pin down the exact edge at which the bank closes. Constrained-random opcode, bank, address and mask streams then mix interrupted bursts, burst stops, precharges and reopens, and expose ordering faults between burst end, precharge and activate.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_BST  = 4'd4,
      CMD_PRE  = 4'd5,
      CMD_AREF = 4'd6,
      CMD_MRS  = 4'd7,
      CMD_DPD  = 4'd8,
      CMD_SREF = 4'd9
   } cmd_e;

   // Opcode plus clock-enable level to command; shared opcodes split on cke.
   function automatic cmd_e pins_to_cmd(input logic cke, input logic cs_n,
                                        input logic ras_n, input logic cas_n,
                                        input logic we_n);
      cmd_e c;
      c = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  c = cke ? CMD_ACT  : CMD_NOP;
            3'b101:  c = cke ? CMD_RD   : CMD_NOP;
            3'b100:  c = cke ? CMD_WR   : CMD_NOP;
            3'b110:  c = cke ? CMD_BST  : CMD_DPD;
            3'b010:  c = cke ? CMD_PRE  : CMD_NOP;
            3'b001:  c = cke ? CMD_AREF : CMD_SREF;
            3'b000:  c = cke ? CMD_MRS  : CMD_NOP;
            default: c = CMD_NOP;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_now,
   output cmd_e cmd_q
);

   assign cmd_now = pins_to_cmd(cke, cs_n, ras_n, cas_n, we_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= CMD_NOP;
      else        cmd_q <= cmd_now;
   end

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
   import sdram_mon_pkg::*;
#(
   parameter int BA_W  = 2,
   parameter int ROW_W = 13,
   localparam int NB   = 1 << BA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd_now,
   input  logic [BA_W-1:0]   ba,
   input  logic [ROW_W-1:0]  row_in,
   input  logic              all_flag,
   input  logic [NB-1:0]     close_mask,
   output logic [NB-1:0]     open_q,
   output logic [NB*ROW_W-1:0] rows_q,
   output logic              err_reopen
);

   logic is_act, is_pre;
   assign is_act = (cmd_now == CMD_ACT);
   assign is_pre = (cmd_now == CMD_PRE);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit, pre_hit;
      assign hit     = (ba == BA_W'(b));
      assign pre_hit = is_pre && (all_flag || hit);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[b]                 <= 1'b0;
            rows_q[b*ROW_W +: ROW_W]  <= '0;
         end else if (close_mask[b] || pre_hit) begin
            open_q[b]                 <= 1'b0;
         end else if (is_act && hit && !open_q[b]) begin
            open_q[b]                 <= 1'b1;
            rows_q[b*ROW_W +: ROW_W]  <= row_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_reopen <= 1'b0;
      else        err_reopen <= is_act && open_q[ba];
   end

endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
   import sdram_mon_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int BURST_LEN = 4,
   parameter int MASK_LAT  = 2,
   localparam int NB       = 1 << BA_W,
   localparam int LEFT_W   = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  cmd_e            cmd_now,
   input  logic [BA_W-1:0] ba,
   input  logic            ap_flag,
   input  logic            dqm,
   input  logic [NB-1:0]   bank_open,
   output logic [NB-1:0]   close_mask,
   output logic            wr_en,
   output logic            rd_oe,
   output logic            err_closed,
   output logic            err_bst
);

   logic [LEFT_W-1:0] left_q;
   logic              rd_q, ap_q;
   logic [BA_W-1:0]   bnk_q;

   logic is_rw, live, start, pre_hit, bst, bst_ok, cont, last_beat;
   logic wr_beat, rd_beat;

   assign is_rw     = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);
   assign live      = (left_q != '0);
   assign start     = is_rw && bank_open[ba];
   assign pre_hit   = live && (cmd_now == CMD_PRE) && (ap_flag || (ba == bnk_q));
   assign bst       = (cmd_now == CMD_BST);
   assign bst_ok    = bst && live && !ap_q;
   assign cont      = live && !start && !bst_ok && !pre_hit;
   assign last_beat = cont && (left_q == LEFT_W'(1));
   assign wr_beat   = (start && cmd_now == CMD_WR) || (cont && !rd_q);
   assign rd_beat   = (start && cmd_now == CMD_RD) || (cont &&  rd_q);

   // Close requests: natural end of an AP burst, AP burst cut short by a new
   // burst, and (single-beat bursts only) an AP command ending on issue.
   for (genvar b = 0; b < NB; b++) begin : g_close
      logic own, now_hit;
      assign own = ap_q && (bnk_q == BA_W'(b)) && (last_beat || (start && live));
      if (BURST_LEN == 1) begin : g_single
         assign now_hit = start && ap_flag && (ba == BA_W'(b));
      end else begin : g_multi
         assign now_hit = 1'b0;
      end
      assign close_mask[b] = own || now_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         rd_q   <= 1'b0;
         ap_q   <= 1'b0;
         bnk_q  <= '0;
      end else if (start) begin
         left_q <= LEFT_W'(BURST_LEN - 1);
         rd_q   <= (cmd_now == CMD_RD);
         ap_q   <= ap_flag;
         bnk_q  <= ba;
      end else if (cont) begin
         left_q <= left_q - LEFT_W'(1);
      end else begin
         left_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         err_closed <= 1'b0;
         err_bst    <= 1'b0;
      end else begin
         wr_en      <= wr_beat && !dqm;
         err_closed <= is_rw && !bank_open[ba];
         err_bst    <= bst && !bst_ok;
      end
   end

   // Read mask pipeline: MASK_LAT+1 registers so the beat sampled at edge k
   // shows on rd_oe after edge k+MASK_LAT.
   logic [MASK_LAT:0] oe_pipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_pipe <= '0;
      else        oe_pipe <= {oe_pipe[MASK_LAT-1:0], rd_beat && !dqm};
   end
   assign rd_oe = oe_pipe[MASK_LAT];

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs
   import sdram_mon_pkg::*;
#(
   parameter int BA_W   = 2,
   parameter int MODE_W = 13
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd_now,
   input  logic [BA_W-1:0]   ba,
   input  logic [MODE_W-1:0] opcode,
   output logic [MODE_W-1:0] base_q,
   output logic [MODE_W-1:0] ext_q,
   output logic              err_reserved
);

   logic is_mrs;
   assign is_mrs = (cmd_now == CMD_MRS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q       <= '0;
         ext_q        <= '0;
         err_reserved <= 1'b0;
      end else begin
         err_reserved <= is_mrs && (ba > BA_W'(1));
         if (is_mrs && ba == BA_W'(0)) base_q <= opcode;
         if (is_mrs && ba == BA_W'(1)) ext_q  <= opcode;
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int ADDR_W    = 13,
   parameter int ROW_W     = 13,
   parameter int AP_BIT    = 10,
   parameter int BURST_LEN = 4,
   parameter int MASK_LAT  = 2,
   localparam int NB       = 1 << BA_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 dqm,
   input  logic [BA_W-1:0]      ba,
   input  logic [ADDR_W-1:0]    addr,
   output logic [3:0]           cmd,
   output logic [NB-1:0]        bank_open,
   output logic [NB*ROW_W-1:0]  open_rows,
   output logic [ADDR_W-1:0]    mode_reg,
   output logic [ADDR_W-1:0]    ext_mode_reg,
   output logic                 wr_en,
   output logic                 rd_oe,
   output logic                 err_closed,
   output logic                 err_reopen,
   output logic                 err_bst,
   output logic                 err_reserved
);

   if (BA_W < 1)          begin : g_chk_ba   $error("BA_W must be at least 1");        end
   if (ROW_W != ADDR_W)   begin : g_chk_row  $error("ROW_W must equal ADDR_W");        end
   if (AP_BIT >= ADDR_W)  begin : g_chk_ap   $error("AP_BIT outside the address");     end
   if (BURST_LEN < 1)     begin : g_chk_bl   $error("BURST_LEN must be at least 1");   end
   if (MASK_LAT < 1)      begin : g_chk_lat  $error("MASK_LAT must be at least 1");    end

   cmd_e           cmd_now, cmd_q;
   logic [NB-1:0]  close_mask;

   sdram_cmd_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke     (cke),
      .cs_n    (cs_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .cmd_now (cmd_now),
      .cmd_q   (cmd_q)
   );
   assign cmd = cmd_q;

   sdram_bank_table #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_now    (cmd_now),
      .ba         (ba),
      .row_in     (addr),
      .all_flag   (addr[AP_BIT]),
      .close_mask (close_mask),
      .open_q     (bank_open),
      .rows_q     (open_rows),
      .err_reopen (err_reopen)
   );

   sdram_burst_track #(.BA_W(BA_W), .BURST_LEN(BURST_LEN), .MASK_LAT(MASK_LAT)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_now    (cmd_now),
      .ba         (ba),
      .ap_flag    (addr[AP_BIT]),
      .dqm        (dqm),
      .bank_open  (bank_open),
      .close_mask (close_mask),
      .wr_en      (wr_en),
      .rd_oe      (rd_oe),
      .err_closed (err_closed),
      .err_bst    (err_bst)
   );

   sdram_mode_regs #(.BA_W(BA_W), .MODE_W(ADDR_W)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_now      (cmd_now),
      .ba           (ba),
      .opcode       (addr),
      .base_q       (mode_reg),
      .ext_q        (ext_mode_reg),
      .err_reserved (err_reserved)
   );

endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk #(
   parameter int BA_W     = 2,
   parameter int ROW_W    = 13,
   parameter int MODE_W   = 13,
   parameter int MASK_LAT = 2,
   localparam int NB      = 1 << BA_W
)(
   input logic                clk,
   input logic                rst_n,
   input logic                cke,
   input logic                cs_n,
   input logic                ras_n,
   input logic                cas_n,
   input logic                we_n,
   input logic                dqm,
   input logic [BA_W-1:0]     ba,
   input logic                a10,
   input logic [3:0]          cmd,
   input logic [NB-1:0]       bank_open,
   input logic [NB*ROW_W-1:0] open_rows,
   input logic [MODE_W-1:0]   mode_reg,
   input logic [MODE_W-1:0]   ext_mode_reg,
   input logic                wr_en,
   input logic                rd_oe,
   input logic                err_closed,
   input logic                err_reopen,
   input logic                err_bst,
   input logic                err_reserved
);

   logic sel;
   logic [2:0] op;
   assign sel = !cs_n && cke;
   assign op  = {ras_n, cas_n, we_n};

   assert_deselect_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd == 4'd0));

   assert_powerdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !cke && op == 3'b110) |=> (cmd == 4'd8));

   assert_reopen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == 3'b011 && bank_open[ba]) |=> (err_reopen && $stable(open_rows)));

   assert_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && (op == 3'b101 || op == 3'b100) && !bank_open[ba]) |=> err_closed);

   assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == 3'b010 && a10) |=> (bank_open == '0));

   assert_mrs_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == 3'b000 && ba > BA_W'(1)) |=>
         (err_reserved && $stable(mode_reg) && $stable(ext_mode_reg)));

   assert_wr_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dqm |=> !wr_en);

   if (MASK_LAT == 2) begin : g_lat2
      assert_rd_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
         dqm |=> ##2 !rd_oe);
   end

   // One command per edge, so at most one error pulse (R8 and neighbours).
   assert_one_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_closed, err_reopen, err_bst, err_reserved}));

endmodule

bind sdram_cmd_monitor sdram_mon_chk #(
   .BA_W(BA_W), .ROW_W(ROW_W), .MODE_W(ADDR_W), .MASK_LAT(MASK_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .a10(addr[AP_BIT]),
   .cmd(cmd), .bank_open(bank_open), .open_rows(open_rows),
   .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg), .wr_en(wr_en),
   .rd_oe(rd_oe), .err_closed(err_closed), .err_reopen(err_reopen),
   .err_bst(err_bst), .err_reserved(err_reserved)
);

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;

   localparam int BL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [3:0]  cmd;
   logic [3:0]  bank_open;
   logic [51:0] open_rows;
   logic [12:0] mode_reg, ext_mode_reg;
   logic wr_en, rd_oe, err_closed, err_reopen, err_bst, err_reserved;

   always #2 clk = ~clk;

   sdram_cmd_monitor u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr),
      .cmd(cmd), .bank_open(bank_open), .open_rows(open_rows),
      .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg), .wr_en(wr_en),
      .rd_oe(rd_oe), .err_closed(err_closed), .err_reopen(err_reopen),
      .err_bst(err_bst), .err_reserved(err_reserved)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   bit        m_open [4];
   bit [12:0] m_row  [4];
   bit [12:0] m_mode, m_ext;
   int        m_left, m_bnk;
   bit        m_rd, m_ap;
   bit        m_pipe [3];
   bit [3:0]  e_cmd;
   bit        e_wr, e_ec, e_eo, e_eb, e_er;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit [3:0] ref_cmd(bit k, bit c, bit [2:0] o);
      if (c) return 4'd0;
      if (!k) begin
         if (o == 3'b110) return 4'd8;
         if (o == 3'b001) return 4'd9;
         return 4'd0;
      end
      case (o)
         3'b011: return 4'd1;
         3'b101: return 4'd2;
         3'b100: return 4'd3;
         3'b110: return 4'd4;
         3'b010: return 4'd5;
         3'b001: return 4'd6;
         3'b000: return 4'd7;
         default: return 4'd0;
      endcase
   endfunction

   task automatic model_reset();
      for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
      m_mode = 0; m_ext = 0; m_left = 0; m_bnk = 0; m_rd = 0; m_ap = 0;
      for (int i = 0; i < 3; i++) m_pipe[i] = 0;
      e_cmd = 0; e_wr = 0; e_ec = 0; e_eo = 0; e_eb = 0; e_er = 0;
   endtask

   task automatic model_step();
      bit [3:0] c;
      bit a10, live, start, pre_hit, bst_ok, cont, wb, rb;
      bit close [4];
      int bi;
      c = ref_cmd(cke, cs_n, {ras_n, cas_n, we_n});
      a10 = addr[10]; bi = int'(ba);
      e_cmd = c; e_ec = 0; e_eo = 0; e_eb = 0; e_er = 0;
      live    = (m_left > 0);
      start   = (c == 2 || c == 3) && m_open[bi];
      e_ec    = (c == 2 || c == 3) && !m_open[bi];
      pre_hit = live && c == 5 && (a10 || bi == m_bnk);
      bst_ok  = (c == 4) && live && !m_ap;
      e_eb    = (c == 4) && !bst_ok;
      cont    = live && !start && !bst_ok && !pre_hit;
      wb = (start && c == 3) || (cont && !m_rd);
      rb = (start && c == 2) || (cont && m_rd);
      for (int b = 0; b < 4; b++) close[b] = 0;
      if (cont && m_left == 1 && m_ap) close[m_bnk] = 1;
      if (start && live && m_ap)       close[m_bnk] = 1;
      if (start && a10 && BL == 1)     close[bi] = 1;
      if (c == 1 && m_open[bi]) e_eo = 1;
      begin
         bit old [4];
         for (int b = 0; b < 4; b++) old[b] = m_open[b];
         for (int b = 0; b < 4; b++) begin
            if (close[b] || (c == 5 && (a10 || bi == b))) m_open[b] = 0;
            else if (c == 1 && bi == b && !old[b]) begin m_open[b] = 1; m_row[b] = addr; end
         end
      end
      if (c == 7) begin
         if (bi == 0) m_mode = addr;
         else if (bi == 1) m_ext = addr;
         else e_er = 1;
      end
      if (start) begin m_left = BL - 1; m_rd = (c == 2); m_ap = a10; m_bnk = bi; end
      else if (cont) m_left = m_left - 1;
      else m_left = 0;
      e_wr = wb && !dqm;
      m_pipe[2] = m_pipe[1]; m_pipe[1] = m_pipe[0]; m_pipe[0] = rb && !dqm;
   endtask

   task automatic compare_all();
      bit [3:0]  eo;
      bit [51:0] er;
      for (int b = 0; b < 4; b++) begin eo[b] = m_open[b]; er[b*13 +: 13] = m_row[b]; end
      chk((e_cmd >= 8) ? "R2" : "R1", "cmd", cmd, e_cmd);
      chk("R6", "bank_open", bank_open, eo);
      chk("R3", "open_rows", open_rows, er);
      chk("R9", "mode_reg", mode_reg, m_mode);
      chk("R9", "ext_mode_reg", ext_mode_reg, m_ext);
      chk("R10", "wr_en", wr_en, e_wr);
      chk("R11", "rd_oe", rd_oe, m_pipe[2]);
      chk("R5", "err_closed", err_closed, e_ec);
      chk("R4", "err_reopen", err_reopen, e_eo);
      chk("R8", "err_bst", err_bst, e_eb);
      chk("R9", "err_reserved", err_reserved, e_er);
   endtask

   // op: 3-bit {ras_n,cas_n,we_n}; drive at negedge, check after posedge
   task automatic apply(input bit k, input bit c, input bit [2:0] o,
                        input bit [1:0] b, input bit [12:0] a, input bit m);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = o; ba = b; addr = a; dqm = m;
      model_step();
      @(posedge clk); #1;
      compare_all();
      @(negedge clk);
   endtask

   localparam bit [2:0] O_NOP = 3'b111, O_ACT = 3'b011, O_RD = 3'b101, O_WR = 3'b100,
                        O_BST = 3'b110, O_PRE = 3'b010, O_REF = 3'b001, O_MRS = 3'b000;

   task automatic nop(input bit m);
      apply(1, 0, O_NOP, 0, 0, m);
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4ns * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'h5D7A_11C3);
      model_reset();
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12", "reset bank_open", bank_open, 0);
      chk("R12", "reset rows", open_rows, 0);
      chk("R12", "reset mode", {mode_reg, ext_mode_reg}, 0);
      chk("R12", "reset flags", {cmd, wr_en, rd_oe, err_closed, err_reopen, err_bst, err_reserved}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: chip select high hides any opcode
      apply(1, 1, O_ACT, 2, 13'h0AAA, 0);
      chk("R1", "deselect keeps banks", bank_open, 0);
      // R2: cke low variants and ignored opcodes
      apply(0, 0, O_BST, 0, 0, 0);
      apply(0, 0, O_REF, 3, 13'h1FFF, 0);
      apply(0, 0, O_ACT, 1, 13'h0123, 0);
      chk("R2", "cke-low ACT ignored", bank_open, 0);
      apply(1, 0, O_REF, 2, 13'h1FFF, 0);
      chk("R2", "refresh ignores address", bank_open, 0);

      // R3/R4: activate then reactivate
      apply(1, 0, O_ACT, 1, 13'h1ABC, 0);
      chk("R3", "bank1 row", open_rows[13 +: 13], 13'h1ABC);
      apply(1, 0, O_ACT, 1, 13'h0555, 0);
      chk("R4", "reopen flag", err_reopen, 1);
      chk("R4", "row kept", open_rows[13 +: 13], 13'h1ABC);
      // R5: read closed bank
      apply(1, 0, O_RD, 2, 0, 0);
      chk("R5", "closed read", err_closed, 1);

      // R7/R10: write with auto precharge, mask 0,1,0,0
      apply(1, 0, O_WR, 1, 13'h0400, 0);
      chk("R10", "beat0 written", wr_en, 1);
      nop(1);
      chk("R10", "beat1 masked", wr_en, 0);
      nop(0);
      chk("R7", "bank open mid-burst", bank_open[1], 1);
      nop(0);
      chk("R7", "bank closed at last beat", bank_open[1], 0);
      nop(0);
      chk("R10", "no beat after burst", wr_en, 0);

      // R11: read without AP, mask high on beat 2
      apply(1, 0, O_ACT, 0, 13'h0010, 0);
      apply(1, 0, O_RD, 0, 13'h0000, 0);
      nop(0);
      chk("R11", "rd_oe not yet", rd_oe, 0);
      nop(1);
      chk("R11", "rd_oe beat0", rd_oe, 1);
      nop(0);
      nop(0);
      chk("R11", "rd_oe beat2 masked", rd_oe, 0);
      nop(0);
      chk("R7", "no-AP bank stays open", bank_open[0], 1);

      // R8: burst stop cases
      apply(1, 0, O_BST, 0, 0, 0);
      chk("R8", "stop with no burst", err_bst, 1);
      apply(1, 0, O_RD, 0, 13'h0400, 0);
      apply(1, 0, O_BST, 0, 0, 0);
      chk("R8", "stop on AP burst", err_bst, 1);
      nop(0); nop(0);
      apply(1, 0, O_ACT, 0, 13'h0077, 0);
      apply(1, 0, O_WR, 0, 0, 0);
      apply(1, 0, O_BST, 0, 0, 0);
      chk("R8", "legal stop", err_bst, 0);
      nop(0);
      chk("R8", "stop ends burst", wr_en, 0);

      // R6: precharge single then all
      apply(1, 0, O_ACT, 3, 13'h0003, 0);
      apply(1, 0, O_PRE, 0, 0, 0);
      chk("R6", "single close", bank_open, 4'b1000);
      apply(1, 0, O_PRE, 1, 13'h0400, 0);
      chk("R6", "close all", bank_open, 0);

      // R9: mode writes
      apply(1, 0, O_MRS, 0, 13'h0032, 0);
      apply(1, 0, O_MRS, 1, 13'h0A05, 0);
      apply(1, 0, O_MRS, 2, 13'h1111, 0);
      chk("R9", "reserved select", err_reserved, 1);
      chk("R9", "base kept", mode_reg, 13'h0032);
      apply(1, 0, O_MRS, 3, 13'h1111, 0);
      chk("R9", "ext kept", ext_mode_reg, 13'h0A05);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit k, c, m;
         bit [2:0] o;
         k = ($urandom % 10) != 0;
         c = ($urandom % 10) == 0;
         m = ($urandom % 4) == 0;
         case ($urandom % 10)
            0, 1:    o = O_ACT;
            2, 3:    o = O_RD;
            4, 5:    o = O_WR;
            6:       o = O_BST;
            7:       o = O_PRE;
            8:       o = ($urandom % 2) ? O_MRS : O_REF;
            default: o = O_NOP;
         endcase
         apply(k, c, o, 2'($urandom), 13'($urandom), m);
      end

      finish_run();
   end

endmodule